// File: doc/BRIEF.md
# Event Counter Bank with Paired Set/Clear Control

The block holds a parameterized bank of event counters (up to 64) behind a simple memory-mapped read/write port. A counter advances by one on each cycle in which its qualify input is high, provided counting is switched on for the whole bank and for that counter. Software can read any counter and can load it with a new value. The usual use is to load half of full scale after each overflow, so the next overflow comes after a known number of events.

All per-counter state changes through pairs of bitmask registers. Writing ones to the "set" address turns the selected bits on. Writing ones to the "clear" address turns them off. Zero bits in the written value leave their counters alone, so no read-modify-write is needed. This covers three kinds of state: counting enables, interrupt enables and overflow flags. A wrap from all ones to zero latches a sticky overflow flag. The level interrupt output is high while the interrupt output enable is on and at least one flagged counter also has its interrupt enable set.

A read-only configuration word reports the number of counters, the counter width and the filter mode. Software uses the width to choose between 4-byte and 8-byte counter access. The same width also fixes the address stride between counters.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset every counter, the counting-enable mask, the interrupt-enable mask, the overflow flags, the bank enable (0xE04 bit 0) and the interrupt output enable (0xE50 bit 0) read as zero, and `irqOut` is low.
- R2: Counter n is located at byte offset n × stride. The stride is 8 when `CTR_WIDTH` is greater than 32 and 4 otherwise. A read returns the counter zero-extended to 64 bits. A write loads the low `CTR_WIDTH` bits of the write data.
- R3: A counter increments by one in a cycle only when the bank enable (0xE04 bit 0), its own enable bit and its `qualify` bit are all 1. Otherwise it holds its value.
- R4: Writing to 0xC00 sets the counting-enable bits that are 1 in the data. Writing to 0xC20 clears them. Zero bits leave the mask unchanged, and a read of either address returns the mask.
- R5: Writing to 0xC40 sets the interrupt-enable bits that are 1 in the data, and writing to 0xC60 clears them. Zero bits have no effect, and a read of either address returns the mask.
- R6: A counter that increments from all ones to zero sets its sticky overflow flag. The flags read at 0xCC0. Writing ones to 0xC80 clears the matching flags, except that a wrap in the same cycle keeps its flag set. 0xC80 reads as zero.
- R7: `irqOut` is high exactly when 0xE50 bit 0 is 1 and some counter has both its overflow flag and its interrupt-enable bit set.
- R8: The word at 0xE00 reads `NUM_CTR`−1 in bits 5:0, `CTR_WIDTH`−1 in bits 13:8, and `GLOBAL_FILTER` in bit 23. All other bits are zero.
- R9: When a write to a counter and an increment of that counter fall in the same cycle, the written value is stored. That increment is lost and does not set the overflow flag.
- R10: Reads of unmapped or misaligned addresses return zero. Writes to them, and writes to 0xCC0 and 0xE00, change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 12 | Byte address for read and write |
| regWrEn | input | 1 | Write strobe, applied at the next rising edge |
| regWrData | input | 64 | Write data |
| regRdData | output | 64 | Read data for `regAddr`, combinational |
| qualify | input | NUM_CTR | Per-counter event pulses |
| irqOut | output | 1 | Level overflow interrupt |

## Verification
If an enable or overflow mask bit is wrong, the fault reaches the ports one cycle after the write or wrap that should have set it. It shows at once in the readback of the set/clear addresses and in `irqOut`. A counter that misses or double-counts an increment keeps its wrong value until software reloads it, so comparing every cycle against a behavioural model catches it at the first read of that counter. The wrap-against-write and wrap-against-clear races only show up if the bench holds counters near all ones. The bench therefore loads such values often, so that the race cycles actually occur.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 64;

  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 12'hC00;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 12'hC20;
  localparam logic [ADDR_W-1:0] OFF_IE_SET  = 12'hC40;
  localparam logic [ADDR_W-1:0] OFF_IE_CLR  = 12'hC60;
  localparam logic [ADDR_W-1:0] OFF_OVF_CLR = 12'hC80;
  localparam logic [ADDR_W-1:0] OFF_OVF_RD  = 12'hCC0;
  localparam logic [ADDR_W-1:0] OFF_CFG     = 12'hE00;
  localparam logic [ADDR_W-1:0] OFF_GLOB    = 12'hE04;
  localparam logic [ADDR_W-1:0] OFF_IRQCTL  = 12'hE50;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTR, RD_EN, RD_IE, RD_OVF, RD_CFG, RD_GLOB, RD_IRQC
  } rdKind_t;

  // Strobes from address decode to the datapath
  typedef struct packed {
    logic              ctrWr;
    logic [5:0]        idx;
    logic              enSet;
    logic              enClr;
    logic              ieSet;
    logic              ieClr;
    logic              ovfClr;
    logic              globWr;
    logic              irqCtlWr;
    rdKind_t           rdKind;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/pcb_ctrl.sv
module pcb_ctrl
  import pcb_pkg::*;
#(
  parameter int NUM_CTR   = 8,
  parameter int CTR_WIDTH = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output strobe_t           stb
);
  localparam int STRIDE_LOG2 = (CTR_WIDTH > 32) ? 3 : 2;
  localparam int CTR_SPAN    = NUM_CTR << STRIDE_LOG2;

  logic       ctrHit;
  logic [5:0] ctrIdx;

  always_comb begin
    ctrHit = (regAddr < ADDR_W'(CTR_SPAN)) &&
             (regAddr[STRIDE_LOG2-1:0] == '0);
    ctrIdx = 6'(regAddr >> STRIDE_LOG2);
  end

  always_comb begin
    stb        = '0;
    stb.data   = regWrData;
    stb.idx    = ctrIdx;
    stb.rdKind = RD_NONE;
    if (ctrHit) begin
      stb.rdKind = RD_CTR;
      stb.ctrWr  = regWrEn;
    end else begin
      unique case (regAddr)
        OFF_EN_SET:  begin stb.rdKind = RD_EN;   stb.enSet    = regWrEn; end
        OFF_EN_CLR:  begin stb.rdKind = RD_EN;   stb.enClr    = regWrEn; end
        OFF_IE_SET:  begin stb.rdKind = RD_IE;   stb.ieSet    = regWrEn; end
        OFF_IE_CLR:  begin stb.rdKind = RD_IE;   stb.ieClr    = regWrEn; end
        OFF_OVF_CLR: begin stb.ovfClr = regWrEn; end
        OFF_OVF_RD:  begin stb.rdKind = RD_OVF; end
        OFF_CFG:     begin stb.rdKind = RD_CFG; end
        OFF_GLOB:    begin stb.rdKind = RD_GLOB; stb.globWr   = regWrEn; end
        OFF_IRQCTL:  begin stb.rdKind = RD_IRQC; stb.irqCtlWr = regWrEn; end
        default: ;
      endcase
    end
  end

  // R10: at most one state-changing strobe per write
  no_multi_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones({stb.ctrWr, stb.enSet, stb.enClr, stb.ieSet, stb.ieClr,
                stb.ovfClr, stb.globWr, stb.irqCtlWr}) <= 1);

  // R10: no strobe without a write
  no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |-> !(stb.ctrWr || stb.enSet || stb.enClr || stb.ieSet ||
                   stb.ieClr || stb.ovfClr || stb.globWr || stb.irqCtlWr));
endmodule

// File: rtl/pcb_datapath.sv
module pcb_datapath
  import pcb_pkg::*;
#(
  parameter int NUM_CTR       = 8,
  parameter int CTR_WIDTH     = 48,
  parameter bit GLOBAL_FILTER = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NUM_CTR-1:0] qualify,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  logic [CTR_WIDTH-1:0] cnt [NUM_CTR];
  logic [NUM_CTR-1:0]   enMask, ieMask, ovfMask;
  logic [NUM_CTR-1:0]   incVec, wrapVec, wrVec;
  logic                 globEn, irqEn;
  logic [NUM_CTR-1:0]   wMask;

  assign wMask = stb.data[NUM_CTR-1:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    assign wrVec[i]   = stb.ctrWr && (stb.idx == 6'(i));
    assign incVec[i]  = globEn && enMask[i] && qualify[i] && !wrVec[i];
    assign wrapVec[i] = incVec[i] && (&cnt[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cnt[i] <= '0;
      else if (wrVec[i])  cnt[i] <= stb.data[CTR_WIDTH-1:0];
      else if (incVec[i]) cnt[i] <= cnt[i] + 1'b1;
    end

    // R3
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(wrVec[i] || (globEn && enMask[i] && qualify[i])) |=> $stable(cnt[i]));

    // R6
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfMask[i]) |-> $past(globEn && enMask[i] && qualify[i] &&
                                  !wrVec[i] && (&cnt[i])));

    // R9
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      wrVec[i] |=> (cnt[i] == $past(stb.data[CTR_WIDTH-1:0])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask  <= '0;
      ieMask  <= '0;
      ovfMask <= '0;
      globEn  <= 1'b0;
      irqEn   <= 1'b0;
    end else begin
      if (stb.enSet)         enMask <= enMask | wMask;
      else if (stb.enClr)    enMask <= enMask & ~wMask;
      if (stb.ieSet)         ieMask <= ieMask | wMask;
      else if (stb.ieClr)    ieMask <= ieMask & ~wMask;
      ovfMask <= (stb.ovfClr ? (ovfMask & ~wMask) : ovfMask) | wrapVec;
      if (stb.globWr)        globEn <= stb.data[0];
      if (stb.irqCtlWr)      irqEn  <= stb.data[0];
    end
  end

  assign irqOut = irqEn && |(ovfMask & ieMask);

  always_comb begin
    rdData = '0;
    unique case (stb.rdKind)
      RD_CTR: begin
        for (int i = 0; i < NUM_CTR; i++)
          if (stb.idx == 6'(i)) rdData = DATA_W'(cnt[i]);
      end
      RD_EN:   rdData = DATA_W'(enMask);
      RD_IE:   rdData = DATA_W'(ieMask);
      RD_OVF:  rdData = DATA_W'(ovfMask);
      RD_CFG: begin
        rdData[5:0]  = 6'(NUM_CTR - 1);
        rdData[13:8] = 6'(CTR_WIDTH - 1);
        rdData[23]   = GLOBAL_FILTER;
      end
      RD_GLOB: rdData[0] = globEn;
      RD_IRQC: rdData[0] = irqEn;
      default: ;
    endcase
  end

  // R4
  en_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enSet || stb.enClr) |=> $stable(enMask));

  // R5
  ie_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.ieSet || stb.ieClr) |=> $stable(ieMask));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ovfClr |=> ((ovfMask & $past(ovfMask)) == $past(ovfMask)));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (irqEn && (ovfMask != '0)));
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CTR       = 8,
  parameter int CTR_WIDTH     = 48,
  parameter bit GLOBAL_FILTER = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [11:0]        regAddr,
  input  logic               regWrEn,
  input  logic [63:0]        regWrData,
  output logic [63:0]        regRdData,
  input  logic [NUM_CTR-1:0] qualify,
  output logic               irqOut
);
  strobe_t stb;

  pcb_ctrl #(.NUM_CTR(NUM_CTR), .CTR_WIDTH(CTR_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .stb(stb)
  );

  pcb_datapath #(.NUM_CTR(NUM_CTR), .CTR_WIDTH(CTR_WIDTH),
                 .GLOBAL_FILTER(GLOBAL_FILTER)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .qualify(qualify),
    .rdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;
  localparam int NCTR = 8;
  localparam int W    = 48;
  localparam longint unsigned MASK = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic [NCTR-1:0] q = '0;
  logic [63:0] rdData;
  logic        irq;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  perf_counter_bank #(.NUM_CTR(NCTR), .CTR_WIDTH(W), .GLOBAL_FILTER(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(addr), .regWrEn(wr), .regWrData(wdata),
    .regRdData(rdData), .qualify(q), .irqOut(irq)
  );

  // Behavioural reference model
  longint unsigned mc [NCTR];
  logic [NCTR-1:0] men = '0, mie = '0, movf = '0;
  bit mg = 0, mi = 0;

  initial for (int i = 0; i < NCTR; i++) mc[i] = 0;

  always @(posedge clk) begin
    logic [NCTR-1:0] incv, wrapv;
    int wi;
    if (!rstN) begin
      for (int i = 0; i < NCTR; i++) mc[i] = 0;
      men = '0; mie = '0; movf = '0; mg = 0; mi = 0;
    end else begin
      wi = -1;
      if (wr && addr < NCTR*8 && addr[2:0] == 3'b000) wi = int'(addr >> 3);
      for (int i = 0; i < NCTR; i++) begin
        incv[i]  = mg && men[i] && q[i] && (wi != i);
        wrapv[i] = incv[i] && (mc[i] == MASK);
      end
      for (int i = 0; i < NCTR; i++) begin
        if (wi == i)      mc[i] = wdata & MASK;
        else if (incv[i]) mc[i] = (mc[i] + 1) & MASK;
      end
      if (wr) begin
        case (addr)
          12'hC00: men  = men | wdata[NCTR-1:0];
          12'hC20: men  = men & ~wdata[NCTR-1:0];
          12'hC40: mie  = mie | wdata[NCTR-1:0];
          12'hC60: mie  = mie & ~wdata[NCTR-1:0];
          12'hC80: movf = movf & ~wdata[NCTR-1:0];
          12'hE04: mg   = wdata[0];
          12'hE50: mi   = wdata[0];
          default: ;
        endcase
      end
      movf = movf | wrapv;
    end
  end

  function automatic longint unsigned expRd(logic [11:0] a);
    if (a < NCTR*8 && a[2:0] == 3'b000) return mc[a >> 3];
    case (a)
      12'hC00, 12'hC20: return 64'(men);
      12'hC40, 12'hC60: return 64'(mie);
      12'hCC0:          return 64'(movf);
      12'hE00:          return 64'h0080_2F07;
      12'hE04:          return 64'(mg);
      12'hE50:          return 64'(mi);
      default:          return 0;
    endcase
  endfunction

  function automatic string tagOf(logic [11:0] a);
    if (a < NCTR*8) return "R2";
    case (a)
      12'hC00, 12'hC20: return "R4";
      12'hC40, 12'hC60: return "R5";
      12'hCC0, 12'hC80: return "R6";
      12'hE00:          return "R8";
      12'hE04:          return "R3";
      default:          return "R10";
    endcase
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, one time unit before the rising edge
  always begin
    @(negedge clk);
    #4;
    if (rstN) begin
      chk(tagOf(addr), rdData, expRd(addr));
      chk("R7", 64'(irq), 64'(mi && |(movf & mie)));
    end
  end

  task automatic cyc(logic [11:0] a, logic w, logic [63:0] d, logic [NCTR-1:0] qq);
    @(negedge clk);
    addr = a; wr = w; wdata = d; q = qq;
  endtask

  task automatic look(string tag, logic [11:0] a, longint unsigned exp);
    cyc(a, 1'b0, '0, '0);
    #4;
    chk(tag, rdData, exp);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [11:0] alist [16];
    alist = '{12'h000, 12'h008, 12'h010, 12'h038, 12'h040, 12'h004, 12'hC00, 12'hC20,
              12'hC40, 12'hC60, 12'hC80, 12'hCC0, 12'hE00, 12'hE04, 12'hE50, 12'hD00};
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    look("R1", 12'h000, 0);
    chk("R1", 64'(irq), 0);
    look("R1", 12'hCC0, 0);
    look("R1", 12'hC00, 0);
    look("R1", 12'hE04, 0);
    look("R1", 12'hE50, 0);
    // R8 configuration
    look("R8", 12'hE00, 64'h0080_2F07);

    // R3 gating: bank enable off, then on
    cyc(12'hC00, 1, 64'h1, '0);
    repeat (5) cyc(12'h000, 0, '0, 8'h01);
    look("R3", 12'h000, 0);
    cyc(12'hE04, 1, 64'h1, '0);
    repeat (5) cyc(12'h000, 0, '0, 8'h01);
    look("R3", 12'h000, 5);
    repeat (3) cyc(12'h008, 0, '0, 8'h02);
    look("R3", 12'h008, 0);

    // R4 / R5 set and clear pairs
    cyc(12'hC00, 1, 64'hF0, '0);
    cyc(12'hC20, 1, 64'h10, '0);
    look("R4", 12'hC20, 64'hE1);
    cyc(12'hC40, 1, 64'h0C, '0);
    cyc(12'hC60, 1, 64'h08, '0);
    look("R5", 12'hC40, 64'h04);

    // R6 / R7 wrap, flag, interrupt
    cyc(12'hE50, 1, 64'h1, '0);
    cyc(12'hC00, 1, 64'h4, '0);
    cyc(12'h010, 1, MASK - 1, '0);
    cyc(12'h010, 0, '0, 8'h04);
    cyc(12'h010, 0, '0, 8'h04);
    look("R6", 12'hCC0, 64'h4);
    chk("R7", 64'(irq), 1);
    look("R2", 12'h010, 0);
    cyc(12'hC60, 1, 64'h4, '0);
    look("R6", 12'hCC0, 64'h4);
    chk("R7", 64'(irq), 0);
    cyc(12'hC80, 1, 64'h4, '0);
    look("R6", 12'hCC0, 0);

    // R9 write beats increment, including at wrap
    cyc(12'h000, 1, 64'h100, 8'h01);
    look("R9", 12'h000, 64'h100);
    cyc(12'h000, 1, MASK, '0);
    cyc(12'h000, 1, 64'h5, 8'h01);
    look("R9", 12'hCC0, 0);
    look("R9", 12'h000, 5);

    // R10 ignored writes and unmapped reads
    cyc(12'hD00, 1, '1, '0);
    cyc(12'hCC0, 1, 64'hFF, '0);
    cyc(12'hE00, 1, '1, '0);
    cyc(12'h004, 1, 64'h7, '0);
    look("R10", 12'hCC0, 0);
    look("R10", 12'h040, 0);
    look("R10", 12'h004, 0);
    look("R10", 12'h000, 5);
    look("R10", 12'hE00, 64'h0080_2F07);

    // Mixed traffic with counters held near all ones
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      logic [63:0] d;
      a = alist[$urandom_range(15)];
      d = {$urandom, $urandom};
      if (a < 12'h040 && $urandom_range(1) == 1) d = MASK - 64'($urandom_range(3));
      cyc(a, ($urandom_range(3) == 0), d, 8'($urandom));
    end
    cyc(12'h000, 0, '0, '0);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule